// File: doc/BRIEF.md
# Rotating Commutator Switch for Radix-4 Stage Reordering

This block sits between a radix-4 butterfly and the bank of complex multipliers that follows it. It takes four complex butterfly results and hands them on to the four multiplier lanes in one of four fixed arrangements. A two-bit pattern index, supplied each processing cycle by the sequencing controller, picks the arrangement. This lets the order of data between transform stages follow the position within the processing cycle without a general crossbar.

Pattern `k` is a cyclic rotation: butterfly result `i` goes to multiplier lane `(i + k) mod 4`. Pattern 0 is the straight-through arrangement. A routing enable gates the whole switch. With the enable low, every output lane reads zero, so idle cycles present clean zeros to the multipliers. Routing is purely combinational from index, enable and data to the outputs. The block holds no state and needs no clock.

Top module: `comm_switch`

## Requirements
- R1: When `route_en` is 0, every real and imaginary output lane is all zeros, whatever the pattern index and input data.
- R2: When `route_en` is 1 and `pat_sel` is 0, output lane `j` carries input lane `j`.
- R3: When `route_en` is 1 and `pat_sel` is 1, input lane `i` appears on output lane `(i + 1) mod 4`.
- R4: When `route_en` is 1 and `pat_sel` is 2, input lane `i` appears on output lane `(i + 2) mod 4`.
- R5: When `route_en` is 1 and `pat_sel` is 3, input lane `i` appears on output lane `(i + 3) mod 4`.
- R6: The imaginary part of each output lane always comes from the same input lane as its real part.
- R7: Outputs follow a change of data, index or enable with no clock-cycle delay: the block has no registers.
- R8: Component values pass bit-exact, including the extremes 0x8000, 0x7FFF, 0xFFFF and 0x0000 (no sign change, saturation or truncation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_re | input | 4 x DW (DW=16) | Real parts of the four butterfly results; element `i` is input lane `i` |
| src_im | input | 4 x DW (DW=16) | Imaginary parts of the four butterfly results |
| pat_sel | input | 2 | Routing pattern index `k`; lane `i` goes to lane `(i+k) mod 4` |
| route_en | input | 1 | 1 routes data to the outputs, 0 forces all outputs to zero |
| dst_re | output | 4 x DW (DW=16) | Real parts presented to the four multiplier lanes |
| dst_im | output | 4 x DW (DW=16) | Imaginary parts presented to the four multiplier lanes |

## Verification
Every result of this block is due in the same cycle as its stimulus: there is no register between any input and any output. The bench therefore changes inputs on the falling clock edge and checks all eight output components one time unit later, well before the next rising edge, so each check sees the settled response to exactly one stimulus. The R7 checks change only the data, and then only the index, while the other inputs stay fixed. They confirm the new values arrive at that same sample point and not a cycle later.

// File: rtl/comm_pkg.sv
// Package: comm_pkg
// Shared constants and helpers for the rotating commutator switch.
// Assumes the lane count is a power of two so that index arithmetic wraps
// naturally modulo the lane count.
package comm_pkg;

    // Default number of complex lanes handled by the switch.
    localparam int unsigned COMM_LANES = 4;

    // Default width of one real or imaginary component.
    localparam int unsigned COMM_DW = 16;

    // Width of an index able to name every lane (and every pattern).
    function automatic int unsigned comm_selw(input int unsigned lanes);
        return (lanes <= 2) ? 1 : $clog2(lanes);
    endfunction

endpackage

// File: rtl/comm_lane_mux.sv
// Module: comm_lane_mux
// One output lane of the commutator. Under rotation pattern k, output lane
// LANE_ID takes input lane (LANE_ID - k) mod LANES. Real and imaginary parts
// use one shared source index so the pair cannot split.
// Assumes LANES is a power of two, so SELW-bit subtraction wraps modulo LANES.
module comm_lane_mux #(
    parameter int unsigned LANES   = comm_pkg::COMM_LANES,
    parameter int unsigned DW      = comm_pkg::COMM_DW,
    parameter int unsigned LANE_ID = 0,
    localparam int unsigned SELW   = comm_pkg::comm_selw(LANES)
) (
    input  logic [LANES-1:0][DW-1:0] src_re,
    input  logic [LANES-1:0][DW-1:0] src_im,
    input  logic [SELW-1:0]          pat_sel,
    output logic [DW-1:0]            lane_re,
    output logic [DW-1:0]            lane_im
);

    logic [SELW-1:0] src_idx;

    // Work out which input lane feeds this output lane under the current pattern.
    always_comb begin
        src_idx = SELW'(LANE_ID) - pat_sel;
    end

    // Pick the real and imaginary parts of that input lane together.
    always_comb begin
        lane_re = src_re[src_idx];
        lane_im = src_im[src_idx];
    end

endmodule

// File: rtl/comm_zero_gate.sv
// Module: comm_zero_gate
// Passes a bank of complex lanes through when the enable is high and forces
// every bit to zero when it is low. Purely combinational.
module comm_zero_gate #(
    parameter int unsigned LANES = comm_pkg::COMM_LANES,
    parameter int unsigned DW    = comm_pkg::COMM_DW
) (
    input  logic                     gate_en,
    input  logic [LANES-1:0][DW-1:0] in_re,
    input  logic [LANES-1:0][DW-1:0] in_im,
    output logic [LANES-1:0][DW-1:0] out_re,
    output logic [LANES-1:0][DW-1:0] out_im
);

    // Pass the lanes through or hold them at zero.
    always_comb begin
        if (gate_en) begin
            out_re = in_re;
            out_im = in_im;
        end else begin
            out_re = '0;
            out_im = '0;
        end
    end

endmodule

// File: rtl/comm_switch.sv
// Module: comm_switch (top)
// Rotating commutator between a radix-4 butterfly and the complex multiplier
// bank. Pattern k sends input lane i to output lane (i + k) mod LANES. With
// route_en low, every output is zero. No state and no clock: the paths from
// index, enable and data to the outputs are combinational.
// Assumes LANES is a power of two (default 4, one pattern per lane offset).
module comm_switch #(
    parameter int unsigned LANES = comm_pkg::COMM_LANES,
    parameter int unsigned DW    = comm_pkg::COMM_DW,
    localparam int unsigned SELW = comm_pkg::comm_selw(LANES)
) (
    input  logic [LANES-1:0][DW-1:0] src_re,
    input  logic [LANES-1:0][DW-1:0] src_im,
    input  logic [SELW-1:0]          pat_sel,
    input  logic                     route_en,
    output logic [LANES-1:0][DW-1:0] dst_re,
    output logic [LANES-1:0][DW-1:0] dst_im
);

    logic [LANES-1:0][DW-1:0] routed_re;
    logic [LANES-1:0][DW-1:0] routed_im;

    // One selector per output lane, each fixed to its own lane offset.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        comm_lane_mux #(
            .LANES   (LANES),
            .DW      (DW),
            .LANE_ID (j)
        ) u_lane (
            .src_re  (src_re),
            .src_im  (src_im),
            .pat_sel (pat_sel),
            .lane_re (routed_re[j]),
            .lane_im (routed_im[j])
        );
    end

    // Zero the routed lanes while the switch is disabled.
    comm_zero_gate #(
        .LANES (LANES),
        .DW    (DW)
    ) u_gate (
        .gate_en (route_en),
        .in_re   (routed_re),
        .in_im   (routed_im),
        .out_re  (dst_re),
        .out_im  (dst_im)
    );

endmodule

// File: rtl/comm_switch_chk.sv
// Module: comm_switch_chk
// Checker bound to comm_switch. The block is combinational with no clock, so
// every check is an immediate assertion evaluated on the settled port values.
// Assumes LANES is a power of two.
module comm_switch_chk #(
    parameter int unsigned LANES = comm_pkg::COMM_LANES,
    parameter int unsigned DW    = comm_pkg::COMM_DW,
    localparam int unsigned SELW = comm_pkg::comm_selw(LANES)
) (
    input logic [LANES-1:0][DW-1:0] src_re,
    input logic [LANES-1:0][DW-1:0] src_im,
    input logic [SELW-1:0]          pat_sel,
    input logic                     route_en,
    input logic [LANES-1:0][DW-1:0] dst_re,
    input logic [LANES-1:0][DW-1:0] dst_im
);

    // Check idle zeros and, when routing, each input lane at its rotated position.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            automatic logic [SELW-1:0] o = SELW'(i) + pat_sel;
            if (!route_en) begin
                assert_zero_when_idle_R1: assert (dst_re[i] == '0 && dst_im[i] == '0);
            end else begin
                if (int'(pat_sel) == 0) begin
                    assert_identity_R2: assert (dst_re[i] == src_re[i]);
                end
                if (int'(pat_sel) == 1) begin
                    assert_rot_one_R3: assert (dst_re[o] == src_re[i]);
                end
                if (int'(pat_sel) == 2) begin
                    assert_rot_two_R4: assert (dst_re[o] == src_re[i]);
                end
                if (int'(pat_sel) == 3) begin
                    assert_rot_three_R5: assert (dst_re[o] == src_re[i]);
                end
                assert_pair_kept_R6: assert (dst_im[o] == src_im[i]);
            end
        end
    end

endmodule

bind comm_switch comm_switch_chk #(
    .LANES (LANES),
    .DW    (DW)
) u_chk (
    .src_re   (src_re),
    .src_im   (src_im),
    .pat_sel  (pat_sel),
    .route_en (route_en),
    .dst_re   (dst_re),
    .dst_im   (dst_im)
);

// File: tb/tb_comm_switch.sv
// Bench for comm_switch: directed corner cases plus seeded random stimulus,
// compared against a rotation model written from the requirements.
module tb_comm_switch;

    localparam int LANES = 4;
    localparam int DW    = 16;

    logic clk = 1'b0;
    logic [LANES-1:0][DW-1:0] src_re;
    logic [LANES-1:0][DW-1:0] src_im;
    logic [1:0]               pat_sel;
    logic                     route_en;
    logic [LANES-1:0][DW-1:0] dst_re;
    logic [LANES-1:0][DW-1:0] dst_im;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // 200 MHz clock paces the stimulus.
    always #2.5 clk = ~clk;

    comm_switch #(.LANES(LANES), .DW(DW)) dut (
        .src_re   (src_re),
        .src_im   (src_im),
        .pat_sel  (pat_sel),
        .route_en (route_en),
        .dst_re   (dst_re),
        .dst_im   (dst_im)
    );

    // Model: input lane feeding output lane j under pattern k.
    function automatic int src_of(input int j, input int k);
        return (j - k + LANES) % LANES;
    endfunction

    function automatic logic [DW-1:0] exp_re(input int j);
        return route_en ? src_re[src_of(j, int'(pat_sel))] : '0;
    endfunction

    function automatic logic [DW-1:0] exp_im(input int j);
        return route_en ? src_im[src_of(j, int'(pat_sel))] : '0;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output component against the model.
    task automatic chk_all(input string tag);
        for (int j = 0; j < LANES; j++) begin
            chk(tag, dst_re[j], exp_re(j));
            chk(tag, dst_im[j], exp_im(j));
        end
    endtask

    function automatic string pat_tag(input int k);
        case (k)
            0:       return "R2";
            1:       return "R3";
            2:       return "R4";
            default: return "R5";
        endcase
    endfunction

    // Apply inputs on the falling edge; sample 1 time unit later.
    task automatic apply(input logic en, input logic [1:0] k);
        @(negedge clk);
        route_en = en;
        pat_sel  = k;
        #1;
    endtask

    task automatic tag_data();
        for (int i = 0; i < LANES; i++) begin
            src_re[i] = DW'(16'hA000 + 16'h0110 * i);
            src_im[i] = DW'(16'h5000 + 16'h0011 * (i + 1));
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        src_re = '0;
        src_im = '0;
        for (int i = 0; i < LANES; i++) begin
            src_re[i] = DW'($urandom);
            src_im[i] = DW'($urandom);
        end
        route_en = 1'b0;
        pat_sel  = 2'd2;
        #1;
        // Initial state: disabled, random data, outputs must be zero (R1).
        chk_all("R1");

        // Every pattern with tagged distinct lanes (R2..R5, imaginary follows: R6).
        tag_data();
        for (int k = 0; k < LANES; k++) begin
            apply(1'b1, 2'(k));
            for (int j = 0; j < LANES; j++) begin
                chk(pat_tag(k), dst_re[j], src_re[(j - k + LANES) % LANES]);
                chk("R6", dst_im[j], src_im[(j - k + LANES) % LANES]);
            end
        end

        // R7: data change with pattern held, seen at the same sample point.
        apply(1'b1, 2'd1);
        @(negedge clk);
        src_re[0] = 16'h1234;
        src_im[0] = 16'h4321;
        #1;
        chk("R7", dst_re[1], 16'h1234);
        chk("R7", dst_im[1], 16'h4321);
        // R7: index change alone is seen at once.
        @(negedge clk);
        pat_sel = 2'd3;
        #1;
        chk("R7", dst_re[3], 16'h1234);
        chk("R7", dst_im[3], 16'h4321);

        // R8: extreme component values pass bit-exact.
        src_re[0] = 16'h8000; src_re[1] = 16'h7FFF; src_re[2] = 16'hFFFF; src_re[3] = 16'h0000;
        src_im[0] = 16'h7FFF; src_im[1] = 16'h8000; src_im[2] = 16'h0000; src_im[3] = 16'hFFFF;
        apply(1'b1, 2'd2);
        chk("R8", dst_re[2], 16'h8000);
        chk("R8", dst_re[3], 16'h7FFF);
        chk("R8", dst_re[0], 16'hFFFF);
        chk("R8", dst_im[3], 16'h8000);
        chk("R8", dst_im[2], 16'h7FFF);

        // R1: disable with a non-zero pattern and live data, then re-enable.
        tag_data();
        apply(1'b0, 2'd3);
        chk_all("R1");
        apply(1'b1, 2'd3);
        chk_all("R5");

        // Seeded random mix of enable, pattern and data.
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            for (int i = 0; i < LANES; i++) begin
                src_re[i] = DW'($urandom);
                src_im[i] = DW'($urandom);
            end
            pat_sel  = 2'($urandom);
            route_en = ($urandom % 4) != 0;
            #1;
            chk_all(route_en ? pat_tag(int'(pat_sel)) : "R1");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule